// File: doc/BRIEF.md
# Timer Interrupt Line Router with Legacy Takeover

The router collects interrupt requests from a bank of timer channels and places each one on one of 32 interrupt output lines, chosen by a 5-bit route number per channel. The router also carries two outside level sources onto fixed lines: an interval-timer level onto line 0 and a real-time-clock level onto line 8. A request from any source that lands on a line raises that line. The 32 lines are registered, so a request appears at the output one clock after it is presented.

A legacy-takeover control input changes the mapping. While takeover is active, channel 0 is wired to line 0 and channel 1 to line 8, whatever their route numbers hold. Channels 2 and above keep using their own route numbers. Both outside sources are cut off from the lines. An enable output tells the interval timer whether it may drive its pin. The router keeps recording the real-time-clock level while it is cut off, so that the level can be put back on line 8 when takeover ends.

Top module: `irq_route_mux`

## Requirements
- R1: During and immediately after a synchronous active-high reset, all 32 lines are 0, `pit_en` is 1 and the recorded clock level is 0.
- R2: With takeover off, a request on channel i raises the line whose index equals that channel's route number. The route number sits in bits [5i+4:5i] of `timer_route`. The line is raised one clock after the request is presented.
- R3: With takeover on, channel 0 drives line 0 and channel 1 drives line 8, whatever their route numbers hold.
- R4: With takeover on, channels 2 and above still drive the line given by their route number.
- R5: With takeover off in both the current and the previous clock, `pit_level` appears on line 0 one clock later.
- R6: `rtc_level` is recorded into a register on every clock. With takeover off, line 8 follows the recorded value, which is two clocks behind the input.
- R7: With takeover on, `pit_level` and `rtc_level` have no effect on any line.
- R8: `pit_en` shows the inverse of the takeover input one clock later. It falls one clock after takeover turns on and rises one clock after it turns off.
- R9: In the clock where takeover turns off, the interval-timer source is blocked, so line 0 stays low unless a channel drives it. Line 8 takes the clock level that was recorded while the source was cut off.
- R10: When several sources map to the same line, their requests are ORed together.
- R11: A one-clock request pulse produces a one-clock pulse on its line, delayed by one clock. Pulses and held levels share the same OR path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_req | input | NUM_TIMERS | Per-channel interrupt request (level or one-clock pulse) |
| timer_route | input | NUM_TIMERS*5 | Per-channel route numbers; channel i in bits [5i+4:5i] |
| legacy_mode | input | 1 | Legacy-takeover control |
| pit_level | input | 1 | Interval-timer interrupt level |
| rtc_level | input | 1 | Real-time-clock interrupt level |
| irq_lines | output | 32 | Registered interrupt output lines |
| pit_en | output | 1 | Interval-timer drive enable |

## Verification
The bound checker watches the following on every clock:
- the reset values;
- the fixed placement of channels 0 and 1 under takeover;
- route-number placement for the last channel in both modes;
- the one-clock pass-through of the interval-timer level;
- the response of `pit_en` to each change of the takeover input;
- the blocked line 0 and the restored line 8 in the clock where takeover turns off.

Other behaviour can only be shown by the bench scenarios. These cover:
- OR merging of channels that share a line;
- single-clock pulse shaping;
- the two-clock delay of the recorded clock level;
- the absence of any effect from the outside sources under takeover;
- a real-time-clock change made while the source is cut off, which must appear on line 8 once takeover turns off.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int IRQ_LINES  = 32;
    localparam int IRQ_LINE_W = $clog2(IRQ_LINES);

    typedef logic [IRQ_LINE_W-1:0] line_idx_t;
    typedef logic [IRQ_LINES-1:0]  line_vec_t;

    // Fixed lines used while legacy takeover is active
    localparam line_idx_t TAKEOVER_LINE_CH0 = line_idx_t'(0);
    localparam line_idx_t TAKEOVER_LINE_CH1 = line_idx_t'(8);

    // Lines fed by the outside sources while takeover is off
    localparam line_idx_t PIT_LINE = line_idx_t'(0);
    localparam line_idx_t RTC_LINE = line_idx_t'(8);

    typedef struct packed {
        logic takeover_q;   // takeover input seen at the previous clock
        logic rtc_rec;      // recorded real-time-clock level
        logic pit_en;       // interval-timer drive enable
    } legacy_state_t;

    // Effective line for a channel, given the takeover state
    function automatic line_idx_t pick_line(input int unsigned chan,
                                            input logic        takeover,
                                            input line_idx_t   field);
        if (takeover && chan == 0)
            return TAKEOVER_LINE_CH0;
        else if (takeover && chan == 1)
            return TAKEOVER_LINE_CH1;
        else
            return field;
    endfunction

endpackage

// File: rtl/irq_route_sel.sv
module irq_route_sel
    import irq_route_pkg::*;
#(
    parameter int unsigned CHAN = 0
) (
    input  logic      req,
    input  line_idx_t route,
    input  logic      takeover,
    output line_vec_t onehot
);
    line_idx_t target;

    always_comb begin
        target = pick_line(CHAN, takeover, route);
        onehot = '0;
        if (req)
            onehot[target] = 1'b1;
    end
endmodule

// File: rtl/irq_legacy_ctrl.sv
module irq_legacy_ctrl
    import irq_route_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      takeover,
    input  logic      pit_level,
    input  logic      rtc_level,
    output line_vec_t src_vec,
    output logic      pit_en
);
    legacy_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.takeover_q <= 1'b0;
            st.rtc_rec    <= 1'b0;
            st.pit_en     <= 1'b1;
        end else begin
            st.takeover_q <= takeover;
            st.rtc_rec    <= rtc_level;
            st.pit_en     <= ~takeover;
        end
    end

    always_comb begin
        src_vec = '0;
        if (!takeover) begin
            // Interval-timer path is held low in the clock takeover ends
            src_vec[PIT_LINE] = pit_level & ~st.takeover_q;
            src_vec[RTC_LINE] = st.rtc_rec;
        end
    end

    assign pit_en = st.pit_en;
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  line_vec_t chan_vec [NUM_SRC],
    input  line_vec_t side_vec,
    output line_vec_t merged
);
    always_comb begin
        merged = side_vec;
        for (int i = 0; i < NUM_SRC; i++)
            merged = merged | chan_vec[i];
    end
endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux
    import irq_route_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    localparam int ROUTE_BITS = NUM_TIMERS * IRQ_LINE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_TIMERS-1:0] timer_req,
    input  logic [ROUTE_BITS-1:0] timer_route,
    input  logic                  legacy_mode,
    input  logic                  pit_level,
    input  logic                  rtc_level,
    output logic [IRQ_LINES-1:0]  irq_lines,
    output logic                  pit_en
);
    line_vec_t chan_vec [NUM_TIMERS];
    line_vec_t side_vec;
    line_vec_t next_lines;
    line_vec_t lines_q;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chan
        irq_route_sel #(.CHAN(g)) u_sel (
            .req      (timer_req[g]),
            .route    (timer_route[g*IRQ_LINE_W +: IRQ_LINE_W]),
            .takeover (legacy_mode),
            .onehot   (chan_vec[g])
        );
    end

    irq_legacy_ctrl u_legacy (
        .clk       (clk),
        .rst       (rst),
        .takeover  (legacy_mode),
        .pit_level (pit_level),
        .rtc_level (rtc_level),
        .src_vec   (side_vec),
        .pit_en    (pit_en)
    );

    irq_line_merge #(.NUM_SRC(NUM_TIMERS)) u_merge (
        .chan_vec (chan_vec),
        .side_vec (side_vec),
        .merged   (next_lines)
    );

    always_ff @(posedge clk) begin
        if (rst)
            lines_q <= '0;
        else
            lines_q <= next_lines;
    end

    assign irq_lines = lines_q;
endmodule

// File: rtl/irq_route_mux_chk.sv
module irq_route_mux_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_TIMERS = 4
) (
    input logic                             clk,
    input logic                             rst,
    input logic [NUM_TIMERS-1:0]            timer_req,
    input logic [NUM_TIMERS*IRQ_LINE_W-1:0] timer_route,
    input logic                             legacy_mode,
    input logic                             pit_level,
    input logic                             rtc_level,
    input logic [IRQ_LINES-1:0]             irq_lines,
    input logic                             pit_en
);
    logic      past_ok;
    line_idx_t last_route;

    assign last_route = timer_route[(NUM_TIMERS-1)*IRQ_LINE_W +: IRQ_LINE_W];

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (irq_lines == '0 && pit_en));

    // R2
    route_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!legacy_mode && timer_req[NUM_TIMERS-1]) |=> irq_lines[$past(last_route)]);

    // R3
    ch0_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (legacy_mode && timer_req[0]) |=> irq_lines[TAKEOVER_LINE_CH0]);

    // R3
    ch1_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (legacy_mode && timer_req[1]) |=> irq_lines[TAKEOVER_LINE_CH1]);

    // R4
    route_takeover_chk: assert property (@(posedge clk) disable iff (rst)
        (legacy_mode && timer_req[NUM_TIMERS-1]) |=> irq_lines[$past(last_route)]);

    // R5
    pit_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !legacy_mode && !$past(legacy_mode) && pit_level) |=> irq_lines[PIT_LINE]);

    // R8
    pit_en_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(legacy_mode)) |=> !pit_en);

    // R8
    pit_en_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(legacy_mode)) |=> pit_en);

    // R9
    exit_block_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(legacy_mode) && timer_req == '0) |=> !irq_lines[PIT_LINE]);

    // R9
    exit_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(legacy_mode) && timer_req == '0)
            |=> (irq_lines[RTC_LINE] == $past(rtc_level, 2)));
endmodule

bind irq_route_mux irq_route_mux_chk #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .timer_req   (timer_req),
    .timer_route (timer_route),
    .legacy_mode (legacy_mode),
    .pit_level   (pit_level),
    .rtc_level   (rtc_level),
    .irq_lines   (irq_lines),
    .pit_en      (pit_en)
);

// File: tb/tb_irq_route_mux.sv
`timescale 1ns/1ps
module tb_irq_route_mux;
    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] timer_req = '0;
    logic [NT*5-1:0] timer_route = '0;
    logic          legacy_mode = 1'b0;
    logic          pit_level = 1'b0;
    logic          rtc_level = 1'b0;
    logic [31:0]   irq_lines;
    logic          pit_en;

    always #5 clk = ~clk;

    irq_route_mux #(.NUM_TIMERS(NT)) dut (
        .clk(clk), .rst(rst), .timer_req(timer_req), .timer_route(timer_route),
        .legacy_mode(legacy_mode), .pit_level(pit_level), .rtc_level(rtc_level),
        .irq_lines(irq_lines), .pit_en(pit_en)
    );

    typedef struct {
        logic [31:0] lines;
        logic        en;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic [4:0] rt [NT];
    logic m_prev_leg = 1'b0;
    logic m_rtc_rec = 1'b0;

    // Driver: applies one cycle of inputs and queues the expected output
    task automatic step(input logic [NT-1:0] req, input logic leg,
                        input logic pit, input logic rtc, input string tag);
        exp_t e;
        @(negedge clk);
        for (int i = 0; i < NT; i++) timer_route[i*5 +: 5] = rt[i];
        timer_req = req; legacy_mode = leg; pit_level = pit; rtc_level = rtc;
        e.lines = '0;
        for (int i = 0; i < NT; i++) begin
            logic [4:0] ln;
            ln = rt[i];
            if (leg && i == 0) ln = 5'd0;
            if (leg && i == 1) ln = 5'd8;
            if (req[i]) e.lines[ln] = 1'b1;
        end
        if (!leg) begin
            if (pit && !m_prev_leg) e.lines[0] = 1'b1;
            if (m_rtc_rec) e.lines[8] = 1'b1;
        end
        e.en = !leg;
        e.tag = tag;
        q.push_back(e);
        m_prev_leg = leg;
        m_rtc_rec = rtc;
    endtask

    // Monitor: compares registered outputs after each edge
    always @(posedge clk) begin
        #2;
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (irq_lines !== e.lines || pit_en !== e.en) begin
                n_fail++;
                $display("FAIL %s: lines=%h pit_en=%b expected lines=%h pit_en=%b",
                         e.tag, irq_lines, pit_en, e.lines, e.en);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rt[0] = 5'd3; rt[1] = 5'd5; rt[2] = 5'd17; rt[3] = 5'd31;
        legacy_mode = 1'b1; pit_level = 1'b1; rtc_level = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values held during reset
        n_run++;
        if (irq_lines !== '0 || pit_en !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: lines=%h pit_en=%b expected lines=0 pit_en=1", irq_lines, pit_en);
        end
        legacy_mode = 1'b0; pit_level = 1'b0; rtc_level = 1'b0;
        rst = 1'b0;

        // R2: each channel to its own route number
        step(4'b0001, 0, 0, 0, "R2 ch0");
        step(4'b0010, 0, 0, 0, "R2 ch1");
        step(4'b0100, 0, 0, 0, "R2 ch2");
        step(4'b1000, 0, 0, 0, "R2 ch3");
        step(4'b1111, 0, 0, 0, "R2 all");
        // R10: shared line
        rt[3] = 5'd17;
        step(4'b1100, 0, 0, 0, "R10 shared");
        step(4'b0100, 0, 0, 0, "R10 one of shared");
        // R11: single-clock pulse
        rt[3] = 5'd31;
        step(4'b1000, 0, 0, 0, "R11 pulse");
        step(4'b0000, 0, 0, 0, "R11 pulse end");
        // R5: interval-timer level passes through
        step(4'b0000, 0, 1, 0, "R5 pit high");
        step(4'b0000, 0, 0, 0, "R5 pit low");
        // R6: clock level recorded, two-clock delay
        step(4'b0000, 0, 0, 1, "R6 rtc set");
        step(4'b0000, 0, 0, 1, "R6 rtc held");
        step(4'b0000, 0, 0, 0, "R6 rtc clr");
        step(4'b0000, 0, 0, 0, "R6 rtc gone");
        // R8, R3, R4, R7: takeover on
        rt[0] = 5'd5; rt[1] = 5'd20;
        step(4'b0000, 1, 1, 1, "R8 en drop R7");
        step(4'b0001, 1, 1, 1, "R3 ch0 line0");
        step(4'b0010, 1, 1, 0, "R3 ch1 line8");
        step(4'b0100, 1, 1, 0, "R4 ch2 route");
        step(4'b0000, 1, 1, 1, "R7 sources blocked");
        // R9: takeover off, recorded clock level restored, line 0 held low
        step(4'b0000, 0, 1, 0, "R9 exit");
        step(4'b0000, 0, 1, 0, "R9 pit returns");
        step(4'b0000, 0, 0, 0, "R9 settle");
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule